// File: doc/BRIEF.md
# Timer Compare Channel

A single output-compare channel that watches one of two free-running timers and reacts when the selected timer reaches a programmed compare value. Software programs an 8-bit control register and a compare value register. The control register selects which timer is the reference, and whether the channel is armed. It also sets the pin action, the repeat behaviour, the timer-reset behaviour and a side-action strobe.

On a recognised match the channel updates its output pin and pulses an interrupt request. It can also request a reset of either the reference timer or the opposite timer, and it can pulse a side-action strobe. An even-indexed channel uses that strobe to reload a waveform generator. An odd-indexed channel uses it to start an A/D conversion. The channel index is a build-time parameter. The timers, the waveform generator and the converter are outside the block: only the reset requests and the strobes leave it.

Top module: `cmp_chan`

## Requirements
- R1: After reset `ctl_o` reads 0x00 and `pin_o`, `irq_o`, `rst_a_o`, `rst_b_o`, `wg_reload_o` and `ad_start_o` are all 0.
- R2: A write with `ctl_we_i` loads `ctl_wdata_i` into the control register, and `ctl_o` shows it after the clock edge. The fields are: bit 7 timer select (TB), bit 6 compare enable (CE), bits 5:4 pin mode, bit 3 repeat enable (RE), bit 2 side-action enable, bit 1 reset-opposite select (ROT), bit 0 reset enable (RT).
- R3: With TB=0 the reference timer is `tmr_a_i` and the opposite timer is `tmr_b_i`. With TB=1 the roles swap. Only the reference timer is compared.
- R4: A match is recognised only while CE=1, at the clock edge where the reference timer equals the compare value and did not equal it at the previous edge. Each match gives a single-cycle `irq_o` pulse in the cycle after that edge.
- R5: Pin mode 00 leaves `pin_o` unchanged, 01 drives it low, 10 drives it high and 11 toggles it. The pin changes at the match edge.
- R6: With RE=0 the match clears CE in the control register, so the channel fires only once. With RE=1, CE stays set.
- R7: With RT=0 a match never asserts `rst_a_o` or `rst_b_o`.
- R8: With RT=1 a match pulses the reset request of the reference timer when ROT=0, and of the opposite timer when ROT=1. The pulse lasts one cycle and coincides with `irq_o`.
- R9: On an even channel (CHAN_IDX even), bit 2 set makes a match pulse `wg_reload_o` together with `irq_o`. `ad_start_o` stays 0.
- R10: On an odd channel, bit 2 set makes a match pulse `ad_start_o` together with `irq_o`. `wg_reload_o` stays 0. With bit 2 clear, neither strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 8 | Control register write data |
| cmp_we_i | input | 1 | Compare value write enable |
| cmp_wdata_i | input | TMR_W | Compare value write data |
| tmr_a_i | input | TMR_W | First timer value |
| tmr_b_i | input | TMR_W | Second timer value |
| ctl_o | output | 8 | Control register contents |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request pulse |
| rst_a_o | output | 1 | Reset request for the first timer |
| rst_b_o | output | 1 | Reset request for the second timer |
| wg_reload_o | output | 1 | Waveform reload strobe (even channel) |
| ad_start_o | output | 1 | A/D start strobe (odd channel) |

## Verification
Some rules are checked by the assertions on every cycle:
- Matches never occur on consecutive edges and only occur while CE is set.
- At most one reset request is active at a time.
- Every reset request and strobe coincides with an interrupt pulse.
- A strobe of the wrong parity never appears.
- Each pin mode has its effect.
- The one-shot clear takes place.

The bench scenarios must show the remaining behaviour, because it depends on the programmed sequence:
- The reference timer follows TB, and the opposite timer is what gets reset when ROT is set.
- A held match fires only once.
- A one-shot channel stays quiet when the timer matches a second time.
- An odd and an even channel respond differently to the same bit 2.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_TOG  = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     tb;
    logic     ce;
    pin_act_e mode;
    logic     re;
    logic     side;
    logic     rot;
    logic     rt;
  } ctl_t;
endpackage

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] tmr_a_i,
  input  logic [TMR_W-1:0] tmr_b_i,
  input  logic [TMR_W-1:0] cmp_i,
  input  logic             tb_i,
  input  logic             ce_i,
  output logic             match_o
);
  logic [TMR_W-1:0] ref_tmr;
  logic             eq, eq_q;

  assign ref_tmr = tb_i ? tmr_b_i : tmr_a_i;
  assign eq      = (ref_tmr == cmp_i);
  assign match_o = ce_i && eq && !eq_q;

  // remember equality so a held value matches only once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  AST_MATCH_NOT_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o); // R4
endmodule

// File: rtl/cmp_pin.sv
module cmp_pin
  import cmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     match_i,
  input  pin_act_e mode_i,
  output logic     pin_o
);
  logic pin_d;

  always_comb begin
    pin_d = pin_o;
    if (match_i) begin
      unique case (mode_i)
        PIN_KEEP: pin_d = pin_o;
        PIN_LOW:  pin_d = 1'b0;
        PIN_HIGH: pin_d = 1'b1;
        PIN_TOG:  pin_d = ~pin_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else         pin_o <= pin_d;
  end

  AST_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == PIN_LOW) |=> !pin_o); // R5
  AST_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == PIN_HIGH) |=> pin_o); // R5
  AST_PIN_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i == PIN_TOG) |=> (pin_o != $past(pin_o))); // R5
  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> $stable(pin_o)); // R5
endmodule

// File: rtl/cmp_action.sv
module cmp_action #(
  parameter int CHAN_IDX = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic tb_i,
  input  logic side_i,
  input  logic rot_i,
  input  logic rt_i,
  output logic irq_o,
  output logic rst_a_o,
  output logic rst_b_o,
  output logic wg_reload_o,
  output logic ad_start_o
);
  localparam bit IS_ODD = (CHAN_IDX % 2) == 1;

  logic tgt_is_a, req_a, req_b, wg_d, ad_d;

  // reference is A when tb=0; rot flips to the opposite timer
  assign tgt_is_a = (tb_i == rot_i);
  assign req_a    = match_i && rt_i && tgt_is_a;
  assign req_b    = match_i && rt_i && !tgt_is_a;

  generate
    if (IS_ODD) begin : g_odd
      assign ad_d = match_i && side_i;
      assign wg_d = 1'b0;
    end else begin : g_even
      assign wg_d = match_i && side_i;
      assign ad_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      rst_a_o     <= 1'b0;
      rst_b_o     <= 1'b0;
      wg_reload_o <= 1'b0;
      ad_start_o  <= 1'b0;
    end else begin
      irq_o       <= match_i;
      rst_a_o     <= req_a;
      rst_b_o     <= req_b;
      wg_reload_o <= wg_d;
      ad_start_o  <= ad_d;
    end
  end

  AST_RT_OFF_NO_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !rt_i) |=> !(rst_a_o || rst_b_o)); // R7
  AST_RESET_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_a_o, rst_b_o})); // R8
  AST_RESET_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_a_o || rst_b_o) |-> irq_o); // R8
  AST_REF_RESET_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && rt_i && !rot_i && !tb_i) |=> rst_a_o); // R8
  AST_STROBE_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wg_reload_o || ad_start_o) |-> irq_o); // R9

  generate
    if (IS_ODD) begin : g_chk_odd
      AST_ODD_NO_WG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wg_reload_o); // R10
    end else begin : g_chk_even
      AST_EVEN_NO_AD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ad_start_o); // R9
    end
  endgenerate
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
  import cmp_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int CHAN_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             cmp_we_i,
  input  logic [TMR_W-1:0] cmp_wdata_i,
  input  logic [TMR_W-1:0] tmr_a_i,
  input  logic [TMR_W-1:0] tmr_b_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             pin_o,
  output logic             irq_o,
  output logic             rst_a_o,
  output logic             rst_b_o,
  output logic             wg_reload_o,
  output logic             ad_start_o
);
  ctl_t             ctl_q;
  logic [TMR_W-1:0] cmp_q;
  logic             match;

  // a software write wins over the one-shot clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q <= ctl_t'(ctl_wdata_i);
    end else if (match && !ctl_q.re) begin
      ctl_q.ce <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  assign ctl_o = ctl_q;

  cmp_match #(.TMR_W(TMR_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tmr_a_i (tmr_a_i),
    .tmr_b_i (tmr_b_i),
    .cmp_i   (cmp_q),
    .tb_i    (ctl_q.tb),
    .ce_i    (ctl_q.ce),
    .match_o (match)
  );

  cmp_pin u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .mode_i  (ctl_q.mode),
    .pin_o   (pin_o)
  );

  cmp_action #(.CHAN_IDX(CHAN_IDX)) u_act (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .match_i     (match),
    .tb_i        (ctl_q.tb),
    .side_i      (ctl_q.side),
    .rot_i       (ctl_q.rot),
    .rt_i        (ctl_q.rt),
    .irq_o       (irq_o),
    .rst_a_o     (rst_a_o),
    .rst_b_o     (rst_b_o),
    .wg_reload_o (wg_reload_o),
    .ad_start_o  (ad_start_o)
  );

  AST_ONESHOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !ctl_q.re && !ctl_we_i) |=> !ctl_o[6]); // R6
  AST_REPEAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && ctl_q.re && !ctl_we_i) |=> ctl_o[6]); // R6
  AST_IRQ_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(ctl_o[6]))); // R4
endmodule

// File: tb/sim_cmp_chan.sv
module sim_cmp_chan;
  localparam int TW = 16;
  localparam logic [TW-1:0] CV = 16'h1234;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wd = '0;
  logic          cmp_we = 1'b0;
  logic [TW-1:0] cmp_wd = '0;
  logic [TW-1:0] ta = '0, tb = '0;

  logic [7:0] ctl0, ctl1;
  logic pin0, irq0, ra0, rb0, wg0, ad0;
  logic pin1, irq1, ra1, rb1, wg1, ad1;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_chan #(.TMR_W(TW), .CHAN_IDX(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd), .tmr_a_i(ta), .tmr_b_i(tb),
    .ctl_o(ctl0), .pin_o(pin0), .irq_o(irq0), .rst_a_o(ra0), .rst_b_o(rb0),
    .wg_reload_o(wg0), .ad_start_o(ad0));

  cmp_chan #(.TMR_W(TW), .CHAN_IDX(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd), .tmr_a_i(ta), .tmr_b_i(tb),
    .ctl_o(ctl1), .pin_o(pin1), .irq_o(irq1), .rst_a_o(ra1), .rst_b_o(rb1),
    .wg_reload_o(wg1), .ad_start_o(ad1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge, then settle; inputs and samples happen here
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wd = v;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [TW-1:0] v);
    cmp_we = 1'b1; cmp_wd = v;
    tick();
    cmp_we = 1'b0;
  endtask

  // move both timers off the compare value
  task automatic idle();
    ta = CV + 1; tb = CV + 1;
    tick();
  endtask

  task automatic run(input logic [TW-1:0] a, input logic [TW-1:0] b);
    ta = a; tb = b;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl0, 8'h00);
    chk("R1 outs", {pin0, irq0, ra0, rb0, wg0, ad0}, 6'b0);
  endtask

  task automatic t_ctl();
    wr_ctl(8'hA5);
    chk("R2 readback", ctl0, 8'hA5);
    wr_ctl(8'h00);
    chk("R2 clear", ctl0, 8'h00);
  endtask

  task automatic t_ce_gate();
    wr_cmp(CV);
    wr_ctl(8'h00);
    idle();
    run(CV, CV);
    chk("R4 ce off", irq0, 1'b0);
    wr_ctl(8'h48);
    idle();
    run(CV, 0);
    chk("R4 match irq", irq0, 1'b1);
    tick();
    chk("R4 held no refire", irq0, 1'b0);
  endtask

  task automatic t_tb();
    wr_ctl(8'h48);
    idle();
    run(0, CV);
    chk("R3 tb0 ignores b", irq0, 1'b0);
    wr_ctl(8'hC8);
    idle();
    run(0, CV);
    chk("R3 tb1 uses b", irq0, 1'b1);
    idle();
    run(CV, 0);
    chk("R3 tb1 ignores a", irq0, 1'b0);
  endtask

  task automatic t_pin();
    wr_ctl(8'h68); idle(); run(CV, 0);
    chk("R5 high", pin0, 1'b1);
    wr_ctl(8'h48); idle(); run(CV, 0);
    chk("R5 keep", pin0, 1'b1);
    wr_ctl(8'h58); idle(); run(CV, 0);
    chk("R5 low", pin0, 1'b0);
    wr_ctl(8'h78); idle(); run(CV, 0);
    chk("R5 toggle1", pin0, 1'b1);
    idle(); run(CV, 0);
    chk("R5 toggle2", pin0, 1'b0);
  endtask

  task automatic t_oneshot();
    wr_ctl(8'h40); idle(); run(CV, 0);
    chk("R6 oneshot irq", irq0, 1'b1);
    chk("R6 ce cleared", ctl0, 8'h00);
    idle(); run(CV, 0);
    chk("R6 no second", irq0, 1'b0);
    wr_ctl(8'h48); idle(); run(CV, 0);
    chk("R6 repeat ce kept", ctl0, 8'h48);
    idle(); run(CV, 0);
    chk("R6 repeat fires", irq0, 1'b1);
  endtask

  task automatic t_treset();
    wr_ctl(8'h48); idle(); run(CV, 0);
    chk("R7 rt off", {ra0, rb0}, 2'b00);
    wr_ctl(8'h49); idle(); run(CV, 0);
    chk("R8 tb0 ref->a", {ra0, rb0}, 2'b10);
    tick();
    chk("R8 one cycle", {ra0, rb0}, 2'b00);
    wr_ctl(8'h4B); idle(); run(CV, 0);
    chk("R8 tb0 opp->b", {ra0, rb0}, 2'b01);
    wr_ctl(8'hC9); idle(); run(0, CV);
    chk("R8 tb1 ref->b", {ra0, rb0}, 2'b01);
    wr_ctl(8'hCB); idle(); run(0, CV);
    chk("R8 tb1 opp->a", {ra0, rb0}, 2'b10);
  endtask

  task automatic t_side();
    wr_ctl(8'h4C); idle(); run(CV, 0);
    chk("R9 even wg", {wg0, ad0}, 2'b10);
    chk("R10 odd ad", {wg1, ad1}, 2'b01);
    tick();
    chk("R9 wg one cycle", wg0, 1'b0);
    wr_ctl(8'h48); idle(); run(CV, 0);
    chk("R10 side off", {wg0, ad0, wg1, ad1}, 4'b0);
  endtask

  initial begin
    #35;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ctl();
    t_ce_gate();
    t_tb();
    t_pin();
    t_oneshot();
    t_treset();
    t_side();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule